// File: doc/BRIEF.md
# Buffer Occupancy Watermark Monitor

This block keeps a live occupancy count, in cells, for a fixed set of buffer accounting points (for example one per port and pool, or per port and traffic class). Each cycle at most one counter may be credited and at most one debited, each by an amount of cells. Next to every live count the block keeps a peak value: the highest occupancy seen since reset or since the last peak restart.

Software-side readers never see the live counters directly. A snapshot strobe copies every counter's current and peak value into a shadow bank in one clock edge. All reads are then served from that bank until the next snapshot, so a set of records read one after another is consistent. A clear-max strobe restarts peak tracking on all counters. The restart begins from each counter's occupancy at that instant, not from zero, so the peak is never reported below the current value.

Top module: `occ_watermark_mon`

## Requirements
- R1: After synchronous reset every live count, peak and shadow value is zero, `rd_valid` is low, and a read of any index returns 0/0.
- R2: An increment adds `inc_amt` to counter `inc_idx` and a decrement subtracts `dec_amt` from counter `dec_idx`. When both hit one counter in a cycle, the increment is applied first and then the decrement.
- R3: The increment step saturates at 2^24-1 (24-bit counts).
- R4: The decrement step saturates at zero.
- R5: Each peak equals the largest current value reached since reset or since the last clear-max, and is never below the current value.
- R6: On `clr_max`, every counter's peak loads that counter's updated current value of the same cycle, including any increment or decrement applied in that cycle.
- R7: On `snap`, all counters' current and peak values, as they stood before that cycle's events, are copied into the shadow bank in one edge.
- R8: Reads return shadow values only: live changes are invisible until the next snapshot.
- R9: `rd_en` sampled at an edge gives `rd_valid` high with `rd_cur`/`rd_max` the next cycle, and `rd_valid` low otherwise. An index at or above `NUM_CNT` returns 0/0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_valid | input | 1 | Increment event strobe |
| inc_idx | input | IDX_W | Counter credited by the increment |
| inc_amt | input | 24 | Cells added |
| dec_valid | input | 1 | Decrement event strobe |
| dec_idx | input | IDX_W | Counter debited by the decrement |
| dec_amt | input | 24 | Cells removed |
| snap | input | 1 | Copy all live values into the shadow bank |
| clr_max | input | 1 | Restart peak tracking on all counters |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Counter index to read |
| rd_valid | output | 1 | Read data valid |
| rd_cur | output | 24 | Current occupancy from the shadow bank |
| rd_max | output | 24 | Peak occupancy from the shadow bank |

## Verification
The hardest situation to reach is one where several events land on the same counter in one edge: a clear-max together with an increment, an increment and a decrement on one index, or a snapshot together with an event that must not appear in the shadow copy. The bench drives these same-cycle combinations directly. It then takes a fresh snapshot and reads the record back, because only the shadow bank is visible at the ports. Saturation at the top of the 24-bit range is reached with one large increment followed by a small one.

// File: rtl/occ_mon_pkg.sv
package occ_mon_pkg;

    localparam int unsigned OCC_W = 24;
    localparam logic [OCC_W-1:0] OCC_TOP = {OCC_W{1'b1}};

    typedef struct packed {
        logic [OCC_W-1:0] cur;
        logic [OCC_W-1:0] peak;
    } occ_rec_t;

    function automatic logic [OCC_W-1:0] sat_add(input logic [OCC_W-1:0] a,
                                                 input logic [OCC_W-1:0] b);
        logic [OCC_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[OCC_W] ? OCC_TOP : s[OCC_W-1:0];
    endfunction

    function automatic logic [OCC_W-1:0] sat_sub(input logic [OCC_W-1:0] a,
                                                 input logic [OCC_W-1:0] b);
        return (b > a) ? '0 : (a - b);
    endfunction

endpackage

// File: rtl/occ_cell.sv
module occ_cell
    import occ_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic [OCC_W-1:0] inc_amt,
    input  logic             dec_en,
    input  logic [OCC_W-1:0] dec_amt,
    input  logic             clr,
    output occ_rec_t         rec
);
    occ_rec_t         rec_q;
    logic [OCC_W-1:0] after_inc;
    logic [OCC_W-1:0] cur_nxt;
    logic [OCC_W-1:0] peak_nxt;

    always_comb begin
        after_inc = inc_en ? sat_add(rec_q.cur, inc_amt) : rec_q.cur;
        cur_nxt   = dec_en ? sat_sub(after_inc, dec_amt) : after_inc;
        if (clr)
            peak_nxt = cur_nxt;
        else if (cur_nxt > rec_q.peak)
            peak_nxt = cur_nxt;
        else
            peak_nxt = rec_q.peak;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else begin
            rec_q.cur  <= cur_nxt;
            rec_q.peak <= peak_nxt;
        end
    end

    assign rec = rec_q;

    p_peak_ge_cur_r5: assert property (@(posedge clk) disable iff (rst)
        rec_q.peak >= rec_q.cur);

    p_clr_loads_cur_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> rec_q.peak == rec_q.cur);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !dec_en && rec_q.cur == OCC_TOP) |=> rec_q.cur == OCC_TOP);

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_en && !inc_en && dec_amt >= rec_q.cur) |=> rec_q.cur == '0);

endmodule

// File: rtl/occ_shadow.sv
module occ_shadow
    import occ_mon_pkg::*;
#(
    parameter int unsigned NUM_CNT = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    snap,
    input  occ_rec_t [NUM_CNT-1:0]  live,
    output occ_rec_t [NUM_CNT-1:0]  held
);
    occ_rec_t [NUM_CNT-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (snap)
            held_q <= live;
    end

    assign held = held_q;

    p_snap_copies_r7: assert property (@(posedge clk) disable iff (rst)
        snap |=> held_q == $past(live));

    p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(held_q));

endmodule

// File: rtl/occ_read_port.sv
module occ_read_port
    import occ_mon_pkg::*;
#(
    parameter int unsigned NUM_CNT = 12,
    parameter int unsigned IDX_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic [IDX_W-1:0]        rd_idx,
    input  occ_rec_t [NUM_CNT-1:0]  held,
    output logic                    rd_valid,
    output occ_rec_t                rd_rec
);
    occ_rec_t sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_idx == IDX_W'(i))
                sel = held[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_rec   <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_rec <= sel;
        end
    end

    p_read_latency_r9: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

endmodule

// File: rtl/occ_watermark_mon.sv
module occ_watermark_mon
    import occ_mon_pkg::*;
#(
    parameter int unsigned NUM_CNT = 12,
    localparam int unsigned IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT + 1) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_valid,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic [23:0]      inc_amt,
    input  logic             dec_valid,
    input  logic [IDX_W-1:0] dec_idx,
    input  logic [23:0]      dec_amt,
    input  logic             snap,
    input  logic             clr_max,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [23:0]      rd_cur,
    output logic [23:0]      rd_max
);
    occ_rec_t [NUM_CNT-1:0] live;
    occ_rec_t [NUM_CNT-1:0] held;
    occ_rec_t               rd_rec;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cell
        logic hit_inc;
        logic hit_dec;
        assign hit_inc = inc_valid && (inc_idx == IDX_W'(g));
        assign hit_dec = dec_valid && (dec_idx == IDX_W'(g));

        occ_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .inc_en  (hit_inc),
            .inc_amt (inc_amt),
            .dec_en  (hit_dec),
            .dec_amt (dec_amt),
            .clr     (clr_max),
            .rec     (live[g])
        );
    end

    occ_shadow #(.NUM_CNT(NUM_CNT)) u_shadow (
        .clk  (clk),
        .rst  (rst),
        .snap (snap),
        .live (live),
        .held (held)
    );

    occ_read_port #(.NUM_CNT(NUM_CNT), .IDX_W(IDX_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .held     (held),
        .rd_valid (rd_valid),
        .rd_rec   (rd_rec)
    );

    assign rd_cur = rd_rec.cur;
    assign rd_max = rd_rec.peak;

endmodule

// File: tb/test_occ_watermark_mon.sv
`timescale 1ns/1ps
module test_occ_watermark_mon;
    localparam int N  = 12;
    localparam int IW = $clog2(N + 1);
    localparam logic [23:0] TOP = 24'hFFFFFF;

    logic clk = 0;
    logic rst = 1;
    logic inc_valid = 0, dec_valid = 0, snap = 0, clr_max = 0, rd_en = 0;
    logic [IW-1:0] inc_idx = 0, dec_idx = 0, rd_idx = 0;
    logic [23:0] inc_amt = 0, dec_amt = 0;
    logic rd_valid;
    logic [23:0] rd_cur, rd_max;

    always #10 clk = ~clk;

    occ_watermark_mon #(.NUM_CNT(N)) i_occ_watermark_mon (
        .clk(clk), .rst(rst),
        .inc_valid(inc_valid), .inc_idx(inc_idx), .inc_amt(inc_amt),
        .dec_valid(dec_valid), .dec_idx(dec_idx), .dec_amt(dec_amt),
        .snap(snap), .clr_max(clr_max),
        .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_cur(rd_cur), .rd_max(rd_max)
    );

    typedef struct {
        logic [23:0] cur;
        logic [23:0] pk;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int checks = 0;
    int errors = 0;
    string tag = "R1";

    logic [23:0] mcur [N];
    logic [23:0] mpk  [N];
    logic [23:0] scur [N];
    logic [23:0] spk  [N];

    task automatic check(input bit ok, input string t, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", t, act, exp);
        end
    endtask

    // Reference model from the requirements, applied at each edge.
    task automatic tick();
        exp_t e;
        if (rd_en) begin
            e.cur = (rd_idx < N) ? scur[rd_idx] : 24'd0;
            e.pk  = (rd_idx < N) ? spk[rd_idx]  : 24'd0;
            e.tag = tag;
            expq.push_back(e);
        end
        if (snap)
            for (int i = 0; i < N; i++) begin scur[i] = mcur[i]; spk[i] = mpk[i]; end
        for (int i = 0; i < N; i++) begin
            longint v;
            v = mcur[i];
            if (inc_valid && inc_idx == i) begin v = v + inc_amt; if (v > TOP) v = TOP; end
            if (dec_valid && dec_idx == i) begin v = v - dec_amt; if (v < 0) v = 0; end
            mcur[i] = 24'(v);
            if (clr_max || mcur[i] > mpk[i]) mpk[i] = mcur[i];
        end
        @(posedge clk);
        @(negedge clk);
        inc_valid = 0; dec_valid = 0; snap = 0; clr_max = 0; rd_en = 0;
    endtask

    task automatic do_inc(input int i, input int a);
        inc_valid = 1; inc_idx = IW'(i); inc_amt = 24'(a); tick();
    endtask

    task automatic do_dec(input int i, input int a);
        dec_valid = 1; dec_idx = IW'(i); dec_amt = 24'(a); tick();
    endtask

    task automatic do_snap();
        snap = 1; tick();
    endtask

    task automatic do_read(input int i, input string t);
        tag = t; rd_en = 1; rd_idx = IW'(i); tick();
    endtask

    // Monitor: pops expected records as read data appears.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (expq.size() == 0) begin
                check(0, "R9 unexpected rd_valid", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(rd_cur == e.cur, {e.tag, " cur"}, rd_cur, e.cur);
                check(rd_max == e.pk,  {e.tag, " max"}, rd_max, e.pk);
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin mcur[i] = 0; mpk[i] = 0; scur[i] = 0; spk[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check(rd_valid == 0, "R1 rd_valid after reset", rd_valid, 0);
        do_read(0, "R1");
        do_read(N - 1, "R1");

        // R2/R8: live updates invisible before a snapshot
        do_inc(3, 100);
        do_inc(3, 50);
        do_dec(3, 30);
        do_read(3, "R8 pre-snapshot");
        tick();
        check(rd_valid == 0, "R9 idle rd_valid", rd_valid, 0);
        do_snap();
        do_read(3, "R2 R5 inc/dec and peak");

        // R2: same-cycle increment and decrement on one counter
        inc_valid = 1; inc_idx = 3; inc_amt = 10;
        dec_valid = 1; dec_idx = 3; dec_amt = 40;
        tick();
        do_snap();
        do_read(3, "R2 same-cycle inc/dec");

        // R4: underflow saturates at zero
        do_dec(3, 1000);
        do_snap();
        do_read(3, "R4 floor at zero");

        // R6: clear with increment on same counter, and on another counter
        do_inc(1, 500);
        do_dec(1, 200);
        clr_max = 1; inc_valid = 1; inc_idx = 3; inc_amt = 7;
        tick();
        do_snap();
        do_read(3, "R6 clear with inc");
        do_read(1, "R6 clear loads current");
        do_inc(1, 20);
        do_snap();
        do_read(1, "R5 peak after clear");

        // R3: saturation at the top
        do_inc(2, 24'hFFFFF0);
        do_inc(2, 24'h100);
        do_snap();
        do_read(2, "R3 ceiling");
        do_dec(2, 5);
        do_snap();
        do_read(2, "R3 R5 peak at ceiling");

        // R7: snapshot excludes events of its own cycle
        do_inc(4, 60);
        snap = 1; inc_valid = 1; inc_idx = 4; inc_amt = 9;
        tick();
        do_read(4, "R7 atomic snapshot");
        do_inc(4, 1000);
        do_read(4, "R8 shadow held");
        do_read(1, "R7 other counter");

        // R9: back-to-back reads and out-of-range index
        tag = "R9 back-to-back a"; rd_en = 1; rd_idx = 2; tick();
        tag = "R9 back-to-back b"; rd_en = 1; rd_idx = 4; tick();
        do_read(N + 1, "R9 out of range");
        tick();
        tick();
        check(expq.size() == 0, "R9 all reads returned", expq.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule